// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns activity on external interrupt lines into one latched request for the CPU. A dedicated active-low interrupt pin is always a source. Four general-purpose port lines can also be added as active-high sources through a static port-enable input, whatever direction those lines are driven in. Each source is first brought into the clock domain by a two-flop synchronizer. Each source then gets its own edge detector. The qualifying events from all sources are OR'd together and set a pending flag.

A mode input selects edge-only or edge-and-level triggering. In edge-only mode a source must fall back to inactive before it can request again. In edge-and-level mode an active level keeps requesting, so several wired-OR sources keep the flag set until all of them let go. One byte-wide status/control register holds an enable bit and the pending flag, and has a write-only acknowledge bit. The CPU request is the pending flag qualified by the enable bit and by the CPU's global interrupt mask. A separate status output carries the synchronized level of the dedicated pin alone.

Top module: `ext_irq_top`

## Requirements
- R1: After reset the register reads 0x80 (enable at bit 7 set, pending at bit 3 clear), `cpuIrq` is 0 and `pinLevel` is 1.
- R2: With `levelTrig`=0, an active-going transition on an enabled port line sets pending on the third rising clock edge after the change. If the line stays high after an acknowledge, pending is not set again. The line must return to 0 and rise again before it can request another time.
- R3: With `levelTrig`=1, an active level on any enabled source sets pending. An acknowledge does not clear pending while that level is held.
- R4: The dedicated pin `irqPinN` is active-low. Its falling edge (and its low level in level mode) requests the same way a rising edge or high level on a port line does.
- R5: When `portEn`=0, the port lines cannot set pending.
- R6: While the enable bit is 0, no source sets pending. The enable bit is written from bit 7 of every register write.
- R7: `cpuIrq` is 1 exactly when pending, the enable bit and NOT `cpuMask` are all true. Pending still gets set while `cpuMask` is 1.
- R8: A write with bit 1 (acknowledge) set clears pending. A write with bit 1 clear leaves pending unchanged. Bit 1 and all unused bits (6:4, 2, 0) always read 0.
- R9: If a qualifying event occurs in the same cycle as an acknowledge, pending stays set.
- R10: `pinLevel` follows the dedicated pin level two cycles late and is unaffected by the port lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPinN | input | 1 | Dedicated interrupt pin, active low |
| portPins | input | 4 | Port lines usable as active-high sources |
| portEn | input | 1 | Static gate adding the port lines to the OR |
| levelTrig | input | 1 | 1 = edge-and-level, 0 = edge only |
| cpuMask | input | 1 | CPU global interrupt mask |
| busWe | input | 1 | Register write strobe |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data |
| pinLevel | output | 1 | Synchronized dedicated pin level |
| cpuIrq | output | 1 | Interrupt request to the CPU |

## Verification
If a synchronizer or previous-sample flop is wrong, it shows up as pending setting on the wrong edge. The bench samples pending at the second and third edges after a pin change, so such a fault appears within four cycles. If the per-source previous sample is stale, edge-only mode re-latches on a held line, or misses a second rise. Either shows in the read data on the cycle after an acknowledge. Faults in the priority between a clear and an event, or in the enable and mask gating, show up as a single wrong bit in `busRdata` or `cpuIrq` on the very next read.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W    = 8;
  localparam int EN_BIT   = 7;
  localparam int PEND_BIT = 3;
  localparam int ACK_BIT  = 1;

  typedef struct packed {
    logic setPend;
    logic clrPend;
    logic loadEn;
    logic enVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/ext_irq_sync_edge.sv
module ext_irq_sync_edge #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] riseOut
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;
  logic [WIDTH-1:0] prevSample;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : gSrc
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage1[gi]     <= 1'b0;
          stage2[gi]     <= 1'b0;
          prevSample[gi] <= 1'b0;
        end else begin
          stage1[gi]     <= rawIn[gi];
          stage2[gi]     <= stage1[gi];
          prevSample[gi] <= stage2[gi];
        end
      end
      assign riseOut[gi] = stage2[gi] & ~prevSample[gi];
    end
  endgenerate

  assign syncOut = stage2;
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int NUM_PORT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqPinN,
  input  logic [NUM_PORT-1:0] portPins,
  input  logic                portEn,
  input  logic                levelTrig,
  input  ctrlStrobe_t         strobe,
  output logic                eventHit,
  output logic                enableBit,
  output logic                pendFlag,
  output logic                pinLevel,
  output logic [REG_W-1:0]    regRead
);
  localparam int NUM_SRC = NUM_PORT + 1;

  logic [NUM_SRC-1:0] srcActive;
  logic [NUM_SRC-1:0] srcSync;
  logic [NUM_SRC-1:0] srcRise;

  // index 0 is the dedicated pin, converted to active-high before sync
  assign srcActive = {portPins & {NUM_PORT{portEn}}, ~irqPinN};

  ext_irq_sync_edge #(.WIDTH(NUM_SRC)) u_syncEdge (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (srcActive),
    .syncOut (srcSync),
    .riseOut (srcRise)
  );

  always_comb begin
    eventHit = |srcRise;
    if (levelTrig) eventHit = eventHit | (|srcSync);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableBit <= 1'b1;
      pendFlag  <= 1'b0;
    end else begin
      if (strobe.loadEn) enableBit <= strobe.enVal;
      if (strobe.setPend)      pendFlag <= 1'b1;
      else if (strobe.clrPend) pendFlag <= 1'b0;
    end
  end

  assign pinLevel = ~srcSync[0];

  always_comb begin
    regRead           = '0;
    regRead[EN_BIT]   = enableBit;
    regRead[PEND_BIT] = pendFlag;
  end
endmodule

// File: rtl/ext_irq_ctrl_unit.sv
module ext_irq_ctrl_unit
  import ext_irq_pkg::*;
(
  input  logic             busWe,
  input  logic [REG_W-1:0] busWdata,
  input  logic             eventHit,
  input  logic             enableBit,
  output ctrlStrobe_t      strobe
);
  always_comb begin
    strobe.setPend = eventHit & enableBit;
    strobe.clrPend = busWe & busWdata[ACK_BIT];
    strobe.loadEn  = busWe;
    strobe.enVal   = busWdata[EN_BIT];
  end
endmodule

// File: rtl/ext_irq_top.sv
module ext_irq_top
  import ext_irq_pkg::*;
#(
  parameter int NUM_PORT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqPinN,
  input  logic [NUM_PORT-1:0] portPins,
  input  logic                portEn,
  input  logic                levelTrig,
  input  logic                cpuMask,
  input  logic                busWe,
  input  logic [REG_W-1:0]    busWdata,
  output logic [REG_W-1:0]    busRdata,
  output logic                pinLevel,
  output logic                cpuIrq
);
  ctrlStrobe_t strobe;
  logic eventHit;
  logic enableBit;
  logic pendFlag;

  ext_irq_ctrl_unit u_ctrl (
    .busWe     (busWe),
    .busWdata  (busWdata),
    .eventHit  (eventHit),
    .enableBit (enableBit),
    .strobe    (strobe)
  );

  ext_irq_datapath #(.NUM_PORT(NUM_PORT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqPinN   (irqPinN),
    .portPins  (portPins),
    .portEn    (portEn),
    .levelTrig (levelTrig),
    .strobe    (strobe),
    .eventHit  (eventHit),
    .enableBit (enableBit),
    .pendFlag  (pendFlag),
    .pinLevel  (pinLevel),
    .regRead   (busRdata)
  );

  assign cpuIrq = pendFlag & enableBit & ~cpuMask;
endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker
  import ext_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             irqPinN,
  input logic             cpuMask,
  input logic             busWe,
  input logic [REG_W-1:0] busWdata,
  input logic [REG_W-1:0] busRdata,
  input logic             pinLevel,
  input logic             cpuIrq
);
  logic [1:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    cpuMask |-> !cpuIrq);

  assert_set_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRdata[PEND_BIT]) |-> $past(busRdata[EN_BIT]));

  assert_pend_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata[PEND_BIT] && !(busWe && busWdata[ACK_BIT])) |=> busRdata[PEND_BIT]);

  assert_pin_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 2'd2) |-> (pinLevel == $past(irqPinN, 2)));
endmodule

bind ext_irq_top ext_irq_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .irqPinN  (irqPinN),
  .cpuMask  (cpuMask),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .pinLevel (pinLevel),
  .cpuIrq   (cpuIrq)
);

// File: tb/ext_irq_top_bench.sv
module ext_irq_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       irqPinN = 1'b1;
  logic [3:0] portPins = 4'h0;
  logic       portEn = 1'b1;
  logic       levelTrig = 1'b0;
  logic       cpuMask = 1'b0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       pinLevel;
  logic       cpuIrq;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ext_irq_top u_ext_irq_top (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .portPins(portPins),
    .portEn(portEn), .levelTrig(levelTrig), .cpuMask(cpuMask),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .pinLevel(pinLevel), .cpuIrq(cpuIrq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] d);
    busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = 8'h00;
  endtask

  task automatic testReset();
    chk("R1 reg", busRdata, 8'h80);
    chk("R1 irq", {7'b0, cpuIrq}, 8'h00);
    chk("R1 pin", {7'b0, pinLevel}, 8'h01);
  endtask

  task automatic testEdgeOnly();
    levelTrig = 1'b0;
    portPins[0] = 1'b1;
    cyc(2);
    chk("R2 latency2", busRdata, 8'h80);
    cyc(1);
    chk("R2 latency3", busRdata, 8'h88);
    chk("R7 irq", {7'b0, cpuIrq}, 8'h01);
    chk("R10 port ignored", {7'b0, pinLevel}, 8'h01);
    wrReg(8'h82);
    cyc(4);
    chk("R2 held no retrigger", busRdata, 8'h80);
    portPins[0] = 1'b0;
    cyc(4);
    portPins[0] = 1'b1;
    cyc(3);
    chk("R2 second rise", busRdata, 8'h88);
    portPins[0] = 1'b0;
    wrReg(8'h82);
    cyc(4);
  endtask

  task automatic testLevel();
    levelTrig = 1'b1;
    portPins[2] = 1'b1;
    cyc(3);
    chk("R3 set", busRdata, 8'h88);
    wrReg(8'h82);
    chk("R3 ack while held", busRdata, 8'h88);
    portPins[2] = 1'b0;
    cyc(3);
    wrReg(8'h82);
    chk("R3 released clear", busRdata, 8'h80);
    levelTrig = 1'b0;
    cyc(2);
  endtask

  task automatic testDedicated();
    irqPinN = 1'b0;
    cyc(2);
    chk("R10 pin low", {7'b0, pinLevel}, 8'h00);
    cyc(1);
    chk("R4 fall sets", busRdata, 8'h88);
    wrReg(8'h82);
    cyc(3);
    chk("R4 edge only held", busRdata, 8'h80);
    irqPinN = 1'b1;
    cyc(3);
    chk("R10 pin high", {7'b0, pinLevel}, 8'h01);
  endtask

  task automatic testPortGate();
    portEn = 1'b0;
    portPins[1] = 1'b1;
    cyc(5);
    chk("R5 gated", busRdata, 8'h80);
    portPins[1] = 1'b0;
    cyc(3);
    portEn = 1'b1;
    cyc(3);
  endtask

  task automatic testEnable();
    wrReg(8'h00);
    chk("R6 disabled read", busRdata, 8'h00);
    portPins[3] = 1'b1;
    cyc(5);
    chk("R6 no set", busRdata, 8'h00);
    chk("R6 irq", {7'b0, cpuIrq}, 8'h00);
    portPins[3] = 1'b0;
    cyc(4);
    wrReg(8'h80);
    chk("R6 reenabled", busRdata, 8'h80);
  endtask

  task automatic testMask();
    cpuMask = 1'b1;
    portPins[0] = 1'b1;
    cyc(3);
    chk("R7 pend under mask", busRdata, 8'h88);
    chk("R7 masked irq", {7'b0, cpuIrq}, 8'h00);
    cpuMask = 1'b0;
    #1;
    chk("R7 unmasked irq", {7'b0, cpuIrq}, 8'h01);
    cyc(1);
  endtask

  task automatic testAck();
    wrReg(8'h80);
    chk("R8 write0 no effect", busRdata, 8'h88);
    wrReg(8'hFF);
    chk("R8 ack clears, unused zero", busRdata, 8'h80);
    portPins[0] = 1'b0;
    cyc(4);
  endtask

  task automatic testCollision();
    portPins[3] = 1'b1;
    cyc(3);
    portPins[3] = 1'b0;
    chk("R9 preset", busRdata, 8'h88);
    portPins[1] = 1'b1;
    cyc(2);
    wrReg(8'h82);
    chk("R9 event wins", busRdata, 8'h88);
    wrReg(8'h82);
    chk("R9 later clear", busRdata, 8'h80);
    portPins[1] = 1'b0;
    cyc(3);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    testReset();
    testEdgeOnly();
    testLevel();
    testDedicated();
    testPortGate();
    testEnable();
    testMask();
    testAck();
    testCollision();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule